// File: doc/BRIEF.md
# Write-Masked Soft Reset Register Bank

This block holds a small set of word-wide control registers whose bits drive software-controlled reset lines, one line per bit, for the peripherals around it. Software reaches the registers over a simple register bus with a byte address, write enable, write data, read enable and read data. Each register sits at a word-aligned byte offset of four times its index. Every register bit leaves the block from a flop as an active-high reset line in one flat vector.

A build-time parameter picks one of two write behaviours. In masked mode a register holds 16 lines, and the upper half of each written word acts as a bit-by-bit write enable for the lower half. One line can then be asserted or released in a single write, without disturbing its neighbours and without a read-modify-write. In plain mode a register holds 32 lines, and a write replaces the whole word.

Top module: `srst_bank`

## Requirements
- R1: After the block's reset, the reset-line vector equals the RST_VAL parameter (all zeros by default, so every line is released).
- R2: Line n is bit (n mod L) of register (n div L), where L is 16 in masked mode and 32 in plain mode. Register k is at byte address 4*k. Address bits [1:0] are ignored. The vector has NUM_REGS*L lines.
- R3: In masked mode, a write with data bit b+16 = 1 and bit b = 1 asserts (sets to 1) line b of the addressed register.
- R4: In masked mode, a write with data bit b+16 = 1 and bit b = 0 releases (clears to 0) line b of the addressed register.
- R5: In masked mode, a write leaves every line whose enable bit b+16 is 0 at its old value, whatever bit b holds.
- R6: In plain mode, a write replaces all 32 lines of the addressed register with the written data.
- R7: While read enable is high, read data shows the addressed register's current lines in the same cycle. In masked mode bits [31:16] read as 0. With read enable low, read data is 0.
- R8: A write to a register index of NUM_REGS or above changes no line. A read from such an index returns 0.
- R9: A write is accepted on the rising clock edge where write enable is high. The lines keep their old values before that edge and show the new values right after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| bus_addr | input | ADDR_W | Byte address; register index is bits [ADDR_W-1:2] |
| bus_we | input | 1 | Write enable |
| bus_wdata | input | 32 | Write data (masked mode: [31:16] enables, [15:0] values) |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | 32 | Read data, combinational from address and read enable |
| rst_lines | output | NUM_REGS*L | Active-high reset lines, one per register bit |

## Verification
The assertions assume the bus inputs are stable around the rising edge. They also assume that write enable and read enable may be high together, and that a read in that case shows the register value from before the write. The bench changes every input only on the falling edge. It draws addresses over the whole address space, so out-of-range indices, misaligned low bits, overlapping reads and writes, and enable patterns with mixed set, clear and hold bits all occur. A masked-mode instance and a plain-mode instance receive the same bus traffic side by side.

// File: rtl/srst_pkg.sv
package srst_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = 16;

  // lines carried by one register for a given mode
  function automatic int lines_per_reg(input int masked);
    return (masked != 0) ? HALF_W : WORD_W;
  endfunction
endpackage

// File: rtl/srst_decode.sv
module srst_decode #(
  parameter int ADDR_W   = 6,
  parameter int NUM_REGS = 4
) (
  input  logic [ADDR_W-1:0]   addr,
  output logic                hit,
  output logic [NUM_REGS-1:0] sel
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;

  always_comb begin
    idx = addr[ADDR_W-1:2];
    hit = (32'(idx) < NUM_REGS);
    for (int k = 0; k < NUM_REGS; k++) begin
      sel[k] = hit && (32'(idx) == k);
    end
  end
endmodule

// File: rtl/srst_word.sv
module srst_word #(
  parameter int               MASKED  = 1,
  parameter int               LINES   = 16,
  parameter logic [LINES-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [31:0]      wdata,
  output logic [LINES-1:0] q
);
  logic [LINES-1:0] q_nxt;

  generate
    if (MASKED != 0) begin : g_masked
      logic [LINES-1:0] en;
      assign en = wdata[31:16];
      always_comb begin
        q_nxt = q;
        if (wr_en) q_nxt = (q & ~en) | (wdata[LINES-1:0] & en);
      end

      AST_MASKED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((q & $past(wdata[31:16])) == ($past(wdata[15:0]) & $past(wdata[31:16]))))
        else $error("masked load"); // R3
      AST_MASKED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((q & $past(wdata[31:16]) & ~$past(wdata[15:0])) == '0))
        else $error("masked clear"); // R4
      AST_MASKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ((q & ~$past(wdata[31:16])) == ($past(q) & ~$past(wdata[31:16]))))
        else $error("masked hold"); // R5
    end else begin : g_plain
      always_comb begin
        q_nxt = q;
        if (wr_en) q_nxt = wdata[LINES-1:0];
      end

      AST_PLAIN_REPLACE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (q == $past(wdata[LINES-1:0])))
        else $error("plain replace"); // R6
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else if (wr_en) q <= q_nxt;
  end

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(q))
    else $error("idle stable"); // R9
endmodule

// File: rtl/srst_rdmux.sv
module srst_rdmux #(
  parameter int NUM_REGS = 4,
  parameter int LINES    = 16
) (
  input  logic                      re,
  input  logic [NUM_REGS-1:0]       sel,
  input  logic [NUM_REGS*LINES-1:0] flat,
  output logic [31:0]               rdata
);
  always_comb begin
    rdata = '0;
    for (int k = 0; k < NUM_REGS; k++) begin
      if (re && sel[k]) rdata[LINES-1:0] = flat[k*LINES +: LINES];
    end
  end
endmodule

// File: rtl/srst_bank.sv
module srst_bank #(
  parameter int ADDR_W   = 6,
  parameter int NUM_REGS = 4,
  parameter int MASKED   = 1,
  parameter logic [NUM_REGS*srst_pkg::lines_per_reg(MASKED)-1:0] RST_VAL = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [31:0]         bus_wdata,
  input  logic                bus_re,
  output logic [31:0]         bus_rdata,
  output logic [NUM_REGS*srst_pkg::lines_per_reg(MASKED)-1:0] rst_lines
);
  localparam int LINES = srst_pkg::lines_per_reg(MASKED);
  localparam int TOTAL = NUM_REGS * LINES;

  logic                hit;
  logic [NUM_REGS-1:0] sel;

  srst_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_decode (
    .addr(bus_addr), .hit(hit), .sel(sel)
  );

  generate
    for (genvar k = 0; k < NUM_REGS; k++) begin : g_reg
      srst_word #(
        .MASKED (MASKED),
        .LINES  (LINES),
        .RST_VAL(RST_VAL[k*LINES +: LINES])
      ) u_word (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(bus_we && sel[k]),
        .wdata(bus_wdata),
        .q    (rst_lines[k*LINES +: LINES])
      );
    end
  endgenerate

  srst_rdmux #(.NUM_REGS(NUM_REGS), .LINES(LINES)) u_rdmux (
    .re(bus_re), .sel(sel), .flat(rst_lines), .rdata(bus_rdata)
  );

  AST_MISS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !hit) |=> $stable(rst_lines))
    else $error("miss write"); // R8
  AST_MISS_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && !hit) |-> (bus_rdata == 32'd0))
    else $error("miss read"); // R8
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |-> (bus_rdata == 32'd0))
    else $error("idle read"); // R7
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel))
    else $error("select"); // R2
  AST_RESET_STATE: assert property (@(posedge clk)
    $rose(rst_n) |-> (rst_lines == RST_VAL))
    else $error("reset state"); // R1
  generate
    if (MASKED != 0) begin : g_upper_chk
      AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[31:16] == 16'd0)
        else $error("upper read"); // R7
    end
  endgenerate
endmodule

// File: tb/srst_bank_tb.sv
module srst_bank_tb;
  localparam int ADDR_W = 6;
  localparam int NR     = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [ADDR_W-1:0] bus_addr;
  logic        bus_we, bus_re;
  logic [31:0] bus_wdata;
  logic [31:0] rd_m, rd_p;
  logic [NR*16-1:0] lines_m;
  logic [NR*32-1:0] lines_p;

  logic [15:0] mod_m [NR];
  logic [31:0] mod_p [NR];
  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  always #10 clk = ~clk;

  srst_bank #(.ADDR_W(ADDR_W), .NUM_REGS(NR), .MASKED(1)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(rd_m), .rst_lines(lines_m)
  );
  srst_bank #(.ADDR_W(ADDR_W), .NUM_REGS(NR), .MASKED(0)) u_plain (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_re(bus_re), .bus_rdata(rd_p), .rst_lines(lines_p)
  );

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [31:0] w);
    return (old & ~w[31:16]) | (w[15:0] & w[31:16]);
  endfunction

  function automatic logic [NR*16-1:0] exp_lines_m();
    logic [NR*16-1:0] v;
    for (int k = 0; k < NR; k++) v[k*16 +: 16] = mod_m[k];
    return v;
  endfunction

  function automatic logic [NR*32-1:0] exp_lines_p();
    logic [NR*32-1:0] v;
    for (int k = 0; k < NR; k++) v[k*32 +: 32] = mod_p[k];
    return v;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_lines(input string req);
    chk({req, " masked lines"}, 128'(lines_m), 128'(exp_lines_m()));
    chk({req, " plain lines"},  128'(lines_p), 128'(exp_lines_p()));
  endtask

  // write: drive on falling edge, lines unchanged before edge (R9), updated after
  task automatic do_write(input logic [ADDR_W-1:0] a, input logic [31:0] d, input string req);
    int idx;
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    #1 check_lines("R9 before edge");
    @(negedge clk);
    bus_we = 1'b0;
    idx = int'(a[ADDR_W-1:2]);
    if (idx < NR) begin
      mod_m[idx] = merge(mod_m[idx], d);
      mod_p[idx] = d;
    end
    check_lines(req);
  endtask

  task automatic do_read(input logic [ADDR_W-1:0] a, input string req);
    int idx;
    @(negedge clk);
    bus_addr = a; bus_re = 1'b1;
    #1;
    idx = int'(a[ADDR_W-1:2]);
    chk({req, " masked read"}, 128'(rd_m), (idx < NR) ? 128'({16'd0, mod_m[idx]}) : 128'd0);
    chk({req, " plain read"},  128'(rd_p), (idx < NR) ? 128'(mod_p[idx]) : 128'd0);
    bus_re = 1'b0;
    #1;
    chk("R7 idle read", 128'({rd_m, rd_p}), 128'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int k = 0; k < NR; k++) begin mod_m[k] = '0; mod_p[k] = '0; end
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_re = 1'b0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1 check_lines("R1 reset");
    do_read(6'h00, "R1 reset");

    do_write(6'h00, 32'h0001_0001, "R3 set bit0");
    do_write(6'h00, 32'h0080_0080, "R3 set bit7");
    do_write(6'h00, 32'h0001_0000, "R4 clear bit0");
    do_write(6'h00, 32'h00F0_FF0F, "R5 hold unenabled");
    do_write(6'h00, 32'h0000_FFFF, "R5 no enables");
    do_write(6'h04, 32'hA5A5_5A5A, "R6 full replace");
    do_write(6'h0D, 32'h8000_8000, "R2 reg3 bit15 misaligned");
    do_read(6'h0E, "R2 reg3 read");
    do_read(6'h04, "R7 reg1 read");
    do_write(6'h10, 32'hFFFF_FFFF, "R8 miss write");
    do_write(6'h3C, 32'hFFFF_FFFF, "R8 top miss write");
    do_read(6'h10, "R8 miss read");
    do_read(6'h3F, "R8 top miss read");

    for (int i = 0; i < 400; i++) begin
      logic [ADDR_W-1:0] a;
      a = ADDR_W'($urandom_range(0, (1 << ADDR_W) - 1));
      if ($urandom_range(0, 2) != 0)
        do_write(a, $urandom(), "R2 R3 R4 R5 R6 random write");
      else
        do_read(a, "R7 R8 random read");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule